// File: doc/BRIEF.md
# Shifted Coarse Timestamp Generator

This block runs one fine 56-bit counter that steps on every reference tick enable (a 19.2 MHz strobe in the system clock domain). Three consumers need time at a coarser scale: a logging path, a tagging path and an address-translation path. Each of them gets a 32-bit stamp made by shifting the fine counter right by its own programmable amount. With a shift of 14, one stamp step is about 853 us. With a shift of 24, one step is about 874 ms.

The logging stamp has a source select. It can follow its shifted counter, or it can follow a legacy millisecond counter. That counter advances once every 19200 reference ticks. A single 32-bit configuration word holds the three shift amounts and the select bit, and one write port loads it. A write never disturbs the fine counter or the millisecond counter.

Top module: `coarse_stamp_gen`

## Requirements
- R1: After reset the fine counter, the millisecond counter, its tick prescaler and the configuration word are all zero, so all three stamps read 0.
- R2: The fine counter (56 bits) rises by exactly one on each clock edge where `tick_en` is high, and holds on every other edge.
- R3: Each stamp equals the low 32 bits of the fine counter shifted right by that stamp's shift amount (0 to 31).
- R4: Configuration field positions: logging shift in bits 4:0, tag shift in bits 12:8, translation shift in bits 20:16, each 5 bits wide.
- R5: Configuration bit 7 picks the logging source: 1 gives the shifted fine counter, 0 gives the legacy millisecond count. The tag and translation stamps always use the shifted fine counter.
- R6: The millisecond counter rises by one on the edge that carries the 19200th reference tick since its previous step, and never at any other edge.
- R7: A write on an edge changes the stamps from that edge onward. The fine counter and the millisecond counter keep counting through the write, including when a tick falls on the same edge.
- R8: Bits 31:21, 15:13 and 6:5 of the configuration word are ignored.
- R9: With no tick and no write on an edge, all three stamps hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable per reference (19.2 MHz) tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to load |
| log_stamp | output | 32 | Logging timestamp (shifted counter or millisecond count) |
| tag_stamp | output | 32 | Tagging timestamp |
| xlat_stamp | output | 32 | Translation-entry timestamp |

## Verification
A configuration write and a reference tick can land on the same edge. The bench provokes this by holding `tick_en` high through a run of back-to-back writes that change every shift and flip the logging select. One such write lands right on the edge where the millisecond prescaler wraps. The bench judges each cycle against a model that applies both effects on that edge: the counters advance by their tick, and the new shifts apply to the advanced count.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int CFG_W    = 32;
  localparam int CFG_SH_W = 5;

  typedef struct packed {
    logic [CFG_SH_W-1:0] xlat_sh;
    logic [CFG_SH_W-1:0] tag_sh;
    logic                log_sel;
    logic [CFG_SH_W-1:0] log_sh;
  } cfg_t;

  // Pull the live fields out of a configuration word; other bits are dropped.
  function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.log_sh  = w[4:0];
    c.log_sel = w[7];
    c.tag_sh  = w[12:8];
    c.xlat_sh = w[20:16];
    return c;
  endfunction
endpackage

// File: rtl/base_ctr.sv
module base_ctr #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/ms_tick_ctr.sv
module ms_tick_ctr #(
  parameter int DIV  = 19200,
  parameter int CW   = 32,
  localparam int PW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [PW-1:0] pre_q,
  output logic          wrap,
  output logic [CW-1:0] ms_q
);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  assign wrap = tick && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (wrap) begin
      pre_q <= '0;
      ms_q  <= ms_q + CW'(1);
    end else if (tick) begin
      pre_q <= pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/stamp_shift.sv
module stamp_shift #(
  parameter int IW = 56,
  parameter int OW = 32,
  parameter int SW = 5
) (
  input  logic [IW-1:0] base,
  input  logic [SW-1:0] shamt,
  output logic [OW-1:0] stamp
);
  localparam int MW = (IW > OW) ? IW : OW;

  function automatic logic [OW-1:0] coarse(input logic [IW-1:0] v,
                                           input logic [SW-1:0] s);
    logic [MW-1:0] t;
    t = MW'(v) >> s;
    return t[OW-1:0];
  endfunction

  assign stamp = coarse(base, shamt);
endmodule

// File: rtl/coarse_stamp_gen.sv
module coarse_stamp_gen
  import stamp_pkg::*;
#(
  parameter int BASE_W  = 56,
  parameter int STAMP_W = 32,
  parameter int MS_DIV  = 19200,
  parameter int MS_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [STAMP_W-1:0] log_stamp,
  output logic [STAMP_W-1:0] tag_stamp,
  output logic [STAMP_W-1:0] xlat_stamp
);
  localparam int LANES = 3;
  localparam int PW    = $clog2(MS_DIV);

  cfg_t                cfg_q;
  logic [BASE_W-1:0]   base_q;
  logic [MS_W-1:0]     ms_q;
  logic [PW-1:0]       pre_q;
  logic                pre_wrap;
  logic [CFG_SH_W-1:0] lane_sh [LANES];
  logic [STAMP_W-1:0]  lane_st [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_decode(cfg_wdata);
  end

  base_ctr #(.W(BASE_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tick_en),
    .cnt   (base_q)
  );

  ms_tick_ctr #(.DIV(MS_DIV), .CW(MS_W)) u_ms (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .pre_q (pre_q),
    .wrap  (pre_wrap),
    .ms_q  (ms_q)
  );

  assign lane_sh[0] = cfg_q.log_sh;
  assign lane_sh[1] = cfg_q.tag_sh;
  assign lane_sh[2] = cfg_q.xlat_sh;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    stamp_shift #(.IW(BASE_W), .OW(STAMP_W), .SW(CFG_SH_W)) u_sh (
      .base  (base_q),
      .shamt (lane_sh[g]),
      .stamp (lane_st[g])
    );
  end

  assign log_stamp  = cfg_q.log_sel ? lane_st[0] : STAMP_W'(ms_q);
  assign tag_stamp  = lane_st[1];
  assign xlat_stamp = lane_st[2];
endmodule

// File: rtl/stamp_gen_chk.sv
module stamp_gen_chk #(
  parameter int BASE_W  = 56,
  parameter int STAMP_W = 32,
  parameter int MS_DIV  = 19200,
  parameter int MS_W    = 32,
  localparam int PW     = $clog2(MS_DIV)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               cfg_we,
  input logic [31:0]        cfg_wdata,
  input logic [BASE_W-1:0]  base_q,
  input logic [MS_W-1:0]    ms_q,
  input logic [PW-1:0]      pre_q,
  input logic               pre_wrap,
  input logic [STAMP_W-1:0] log_stamp,
  input logic [STAMP_W-1:0] tag_stamp,
  input logic [STAMP_W-1:0] xlat_stamp
);
  p_base_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> base_q == BASE_W'($past(base_q) + BASE_W'(1)));

  p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(base_q));

  p_ms_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wrap |=> ms_q == MS_W'($past(ms_q) + MS_W'(1)));

  p_ms_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_wrap |=> $stable(ms_q));

  p_pre_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q < PW'(MS_DIV));

  p_tag_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !tick_en && cfg_wdata[12:8] == 5'd0) |=> tag_stamp == STAMP_W'(base_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cfg_we) |=> ($stable(log_stamp) && $stable(tag_stamp) && $stable(xlat_stamp)));
endmodule

bind coarse_stamp_gen stamp_gen_chk #(
  .BASE_W(BASE_W), .STAMP_W(STAMP_W), .MS_DIV(MS_DIV), .MS_W(MS_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .base_q     (base_q),
  .ms_q       (ms_q),
  .pre_q      (pre_q),
  .pre_wrap   (pre_wrap),
  .log_stamp  (log_stamp),
  .tag_stamp  (tag_stamp),
  .xlat_stamp (xlat_stamp)
);

// File: tb/coarse_stamp_gen_tb_top.sv
module coarse_stamp_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] log_stamp, tag_stamp, xlat_stamp;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Bench model state
  logic [63:0] m_base = '0;
  int          m_pre  = 0;
  logic [31:0] m_ms   = '0;
  int          m_lsh = 0, m_tsh = 0, m_xsh = 0;
  bit          m_sel = 1'b0;

  logic [31:0] q_l[$], q_t[$], q_x[$];
  string       q_r[$];

  always #10 clk = ~clk;

  coarse_stamp_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .log_stamp  (log_stamp),
    .tag_stamp  (tag_stamp),
    .xlat_stamp (xlat_stamp)
  );

  function automatic logic [31:0] exp_sh(input logic [63:0] b, input int s);
    logic [63:0] t;
    t = b >> s;
    return t[31:0];
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, advances the model, queues expectation
  task automatic step(input bit t, input bit we, input logic [31:0] wd, input string req);
    @(negedge clk);
    tick_en   = t;
    cfg_we    = we;
    cfg_wdata = wd;
    @(posedge clk);
    if (t) begin
      m_base = (m_base + 64'd1) & 64'h00FF_FFFF_FFFF_FFFF;
      if (m_pre == 19199) begin m_pre = 0; m_ms = m_ms + 32'd1; end
      else m_pre++;
    end
    if (we) begin
      m_lsh = int'(wd[4:0]);  m_sel = wd[7];
      m_tsh = int'(wd[12:8]); m_xsh = int'(wd[20:16]);
    end
    q_l.push_back(m_sel ? exp_sh(m_base, m_lsh) : m_ms);
    q_t.push_back(exp_sh(m_base, m_tsh));
    q_x.push_back(exp_sh(m_base, m_xsh));
    q_r.push_back(req);
  endtask

  // Monitor: compares the queued expectation one half-cycle after the edge
  always @(negedge clk) begin
    if (q_l.size() > 0) begin
      string r;
      r = q_r.pop_front();
      cmp(r, "log",  log_stamp,  q_l.pop_front());
      cmp(r, "tag",  tag_stamp,  q_t.pop_front());
      cmp(r, "xlat", xlat_stamp, q_x.pop_front());
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, all stamps zero
    cmp("R1", "log",  log_stamp,  32'd0);
    cmp("R1", "tag",  tag_stamp,  32'd0);
    cmp("R1", "xlat", xlat_stamp, 32'd0);

    // R4/R3: log shift 0 with select 1, tag shift 0, translation shift 4
    step(1'b0, 1'b1, 32'h0004_0080, "R4");
    // R2/R9: ticks interleaved with idle cycles
    for (int i = 0; i < 300; i++) step((i % 3) != 1, 1'b0, '0, "R2");
    for (int i = 0; i < 10; i++)  step(1'b0, 1'b0, '0, "R9");

    // R3: other shifts, including 31 and 1
    step(1'b1, 1'b1, 32'h001F_0181, "R3");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, '0, "R3");

    // R8: same fields with every ignored bit set must behave identically
    step(1'b1, 1'b1, 32'hFFE0_E060 | 32'h0002_0381, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0, "R8");

    // R5: logging select 0 uses the millisecond count; shifts 14 on tag, 24 on translation
    step(1'b1, 1'b1, 32'h0018_0E0E, "R5");
    for (int i = 0; i < 20000; i++) step(1'b1, 1'b0, '0, "R5");

    // R6: run the prescaler up to just before its second wrap
    while (m_pre != 19195) step(1'b1, 1'b0, '0, "R6");

    // R7: writes that coincide with ticks, across the prescaler wrap
    for (int i = 0; i < 12; i++)
      step(1'b1, 1'b1, {11'd0, 5'(i + 3), 3'd0, 5'(14 - i), (i % 2 == 0), 2'd0, 5'(i)}, "R7");
    step(1'b0, 1'b1, 32'h0000_0E8E, "R7");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, '0, "R6");
    for (int i = 0; i < 5; i++)  step(1'b0, 1'b0, '0, "R9");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule